// File: doc/BRIEF.md
# Trap Priority Selection Unit

This block sits between the fault detectors of one pipeline stage and the trap-entry sequencer. Every cycle it samples the exceptions pending for the instruction in that stage, picks the most urgent one under a fixed architectural ranking, and presents its 9-bit trap type code on a registered output one clock later. Several unrelated faults share a ranking level; among equals the smaller trap code wins.

Fixed faults are requested through a 128-bit vector whose bit k asks for trap type k. Vectored classes come in on their own inputs: four register-window handler classes (spill and fill, each in a normal and an other flavour) carrying a handler index, a software trap carrying a trap number, and fifteen interrupt levels. Each vectored class forms its code as a class base plus the index, number or level.

Top module: `trap_prio_sel`

## Requirements
- R1: Reset is synchronous and active low; while `rst_n` is low at a rising edge, `trap_vld` and `trap_type` become 0 regardless of the request inputs.
- R2: A power-on reset request (`req_fixed[1]`) always wins and yields type 0x001, whatever else is pending.
- R3: When pending requests share a ranking level, the one with the smaller trap type code wins (e.g. 0x002 over 0x005, 0x009 over any interrupt, 0x040 over any interrupt, spill normal over fill other).
- R4: A smaller ranking number is more urgent. Ranking by code: 0x001→0; 0x002–0x005→1; 0x009, 0x040→2; 0x00A→3; 0x029→4; 0x008→5; 0x011, 0x012, 0x013→6; 0x010→7; 0x020→8; 0x024, 0x034, 0x035, 0x036, 0x038, 0x039→10; 0x021, 0x022, 0x037→11; 0x030–0x033→12; 0x023→14; 0x028→15.
- R5: Window classes rank at 9. `win_req[s]` with index `win_idx[5s+4:5s]` yields 0x080 + 0x20·s + index, where s=0 is spill normal, 1 spill other, 2 fill normal, 3 fill other.
- R6: A software trap (`swt_req`) ranks at 16, the least urgent, and yields 0x100 + `swt_num`.
- R7: Interrupts rank at 2; bit j of `intr_pend` is level j+1 and yields 0x041 + j; among pending levels the highest wins.
- R8: Bits of `req_fixed` whose index is not a code listed in R4 are ignored: alone they give no valid output and they never change the selection.
- R9: `trap_vld` is 1 exactly one cycle after an edge at which at least one recognised request was sampled, and 0 in the cycle after an edge with none.
- R10: Whenever `trap_vld` is 0, `trap_type` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_fixed | input | 128 | Bit k requests fixed trap type k |
| win_req | input | 4 | Window handler class requests (spill normal, spill other, fill normal, fill other) |
| win_idx | input | 20 | Four 5-bit handler indices, slot s at bits [5s+4:5s] |
| swt_req | input | 1 | Software trap request |
| swt_num | input | 7 | Software trap number |
| intr_pend | input | 15 | Pending interrupt levels, bit j is level j+1 |
| trap_vld | output | 1 | Registered: a trap was selected |
| trap_type | output | 9 | Registered trap type code of the winner |

## Verification
The bench targets ties inside a ranking level, where a design comparing only ranking numbers would let the later or larger code through, and the interrupt crossing with the level-2 fixed faults, where a wrong base or a lowest-level encoder would return the wrong code or let an interrupt beat 0x009. It sends unlisted fixed bits alone and alongside real requests, which catches a decoder that treats unknown codes as urgent. Vector composition is pushed to its extremes (index 31, trap number 127) to expose carries into the class base, and request drops check that the valid flag does not hold over.

// File: rtl/tsel_pkg.sv
// Package: shared constants, the fixed-fault ranking table and the
// comparison-key packing for the trap priority selection unit.
// Assumes a key compares correctly as an unsigned number: idle flag on top,
// then ranking, then trap code, so the smallest key is the winner.
package tsel_pkg;

    localparam int TT_W      = 9;
    localparam int PRIO_W    = 5;
    localparam int FIX_N     = 128;
    localparam int FIX_IDX_W = $clog2(FIX_N);
    localparam int KEY_W     = 1 + PRIO_W + TT_W;
    localparam int WIN_SLOTS = 4;

    localparam logic [PRIO_W-1:0] PRIO_NONE = 5'd31;
    localparam logic [PRIO_W-1:0] PRIO_INTR = 5'd2;
    localparam logic [PRIO_W-1:0] PRIO_WIN  = 5'd9;
    localparam logic [PRIO_W-1:0] PRIO_SWT  = 5'd16;

    localparam int WIN_BASE  = 'h080;
    localparam int WIN_STEP  = 'h020;
    localparam int SWT_BASE  = 'h100;
    localparam int INT_BASE  = 'h041;

    // Ranking of each fixed trap code; unlisted codes return PRIO_NONE.
    function automatic logic [PRIO_W-1:0] fixed_prio(input logic [FIX_IDX_W-1:0] c);
        logic [PRIO_W-1:0] p;
        case (c)
            7'h01:                               p = 5'd0;
            7'h02, 7'h03, 7'h04, 7'h05:          p = 5'd1;
            7'h09, 7'h40:                        p = 5'd2;
            7'h0A:                               p = 5'd3;
            7'h29:                               p = 5'd4;
            7'h08:                               p = 5'd5;
            7'h11, 7'h12, 7'h13:                 p = 5'd6;
            7'h10:                               p = 5'd7;
            7'h20:                               p = 5'd8;
            7'h24, 7'h34, 7'h35, 7'h36,
            7'h38, 7'h39:                        p = 5'd10;
            7'h21, 7'h22, 7'h37:                 p = 5'd11;
            7'h30, 7'h31, 7'h32, 7'h33:          p = 5'd12;
            7'h23:                               p = 5'd14;
            7'h28:                               p = 5'd15;
            default:                             p = PRIO_NONE;
        endcase
        return p;
    endfunction

    // Pack a candidate into its comparison key (smaller wins).
    function automatic logic [KEY_W-1:0] make_key(input logic vld,
                                                  input logic [PRIO_W-1:0] p,
                                                  input logic [TT_W-1:0] c);
        return {~vld, p, c};
    endfunction

endpackage

// File: rtl/tsel_irq_enc.sv
// Interrupt level encoder: finds the highest pending interrupt level.
// Assumes bit j of the pending vector stands for level j+1.
module tsel_irq_enc #(
    parameter int INT_LVLS = 15,
    localparam int LVL_W   = $clog2(INT_LVLS)
) (
    input  logic [INT_LVLS-1:0] intr_pend,
    output logic                hit,
    output logic [LVL_W-1:0]    top_idx
);

    // Scan upward so the highest pending level is the last one kept.
    always_comb begin
        hit     = 1'b0;
        top_idx = '0;
        for (int j = 0; j < INT_LVLS; j++) begin
            if (intr_pend[j]) begin
                hit     = 1'b1;
                top_idx = LVL_W'(j);
            end
        end
    end

    // Check that the chosen level is pending and nothing above it is.
    always_comb begin
        if (!$isunknown(intr_pend) && hit) begin
            // R7
            irq_pick_chk: assert ((intr_pend >> top_idx) == INT_LVLS'(1))
                else $error("irq_pick_chk: level %0d not the highest pending", top_idx);
        end
    end

endmodule

// File: rtl/tsel_cand_gen.sv
// Candidate generator: turns every request source into a comparison key.
// Assumes window indices fit inside one 32-code class span and software
// trap numbers fit below 0x200 after the base is added.
module tsel_cand_gen
    import tsel_pkg::*;
#(
    parameter int WIN_IDX_W = 5,
    parameter int SWT_W     = 7,
    parameter int INT_LVLS  = 15,
    localparam int LVL_W    = $clog2(INT_LVLS),
    localparam int N_CAND   = FIX_N + WIN_SLOTS + 2
) (
    input  logic [FIX_N-1:0]               req_fixed,
    input  logic [WIN_SLOTS-1:0]           win_req,
    input  logic [WIN_SLOTS*WIN_IDX_W-1:0] win_idx,
    input  logic                           swt_req,
    input  logic [SWT_W-1:0]               swt_num,
    input  logic                           intr_hit,
    input  logic [LVL_W-1:0]               intr_idx,
    output logic [KEY_W-1:0]               cand [N_CAND]
);

    localparam int SWT_SLOT = FIX_N + WIN_SLOTS;
    localparam int INT_SLOT = FIX_N + WIN_SLOTS + 1;

    generate
        // Fixed faults: the bit position is the trap code itself.
        for (genvar k = 0; k < FIX_N; k++) begin : g_fix
            localparam logic [PRIO_W-1:0] P = fixed_prio(FIX_IDX_W'(k));
            assign cand[k] = make_key(req_fixed[k] && (P != PRIO_NONE), P, TT_W'(k));
        end
        // Window handler classes: class base plus handler index.
        for (genvar s = 0; s < WIN_SLOTS; s++) begin : g_win
            localparam logic [TT_W-1:0] BASE = TT_W'(WIN_BASE + WIN_STEP * s);
            logic [TT_W-1:0] code;
            assign code = BASE + {{(TT_W-WIN_IDX_W){1'b0}}, win_idx[s*WIN_IDX_W +: WIN_IDX_W]};
            assign cand[FIX_N+s] = make_key(win_req[s], PRIO_WIN, code);
        end
    endgenerate

    // Software trap: base plus trap number, least urgent ranking.
    assign cand[SWT_SLOT] = make_key(swt_req, PRIO_SWT,
                                     TT_W'(SWT_BASE) + {{(TT_W-SWT_W){1'b0}}, swt_num});

    // Interrupt: base plus zero-based level index.
    assign cand[INT_SLOT] = make_key(intr_hit, PRIO_INTR,
                                     TT_W'(INT_BASE) + {{(TT_W-LVL_W){1'b0}}, intr_idx});

endmodule

// File: rtl/tsel_min_tree.sv
// Minimum-key reduction tree: a balanced binary tree of comparators that
// returns the smallest key among its leaves. Unused leaves are padded
// with all-ones keys, which are idle and lose every comparison.
module tsel_min_tree #(
    parameter int N_IN  = 134,
    parameter int KEY_W = 15,
    localparam int LVLS = $clog2(N_IN),
    localparam int P    = 1 << LVLS
) (
    input  logic [KEY_W-1:0] leaf [N_IN],
    output logic [KEY_W-1:0] win_key
);

    logic [KEY_W-1:0] node [2*P-1];

    generate
        // Leaves: real candidates then idle padding.
        for (genvar i = 0; i < P; i++) begin : g_leaf
            if (i < N_IN) begin : g_real
                assign node[P-1+i] = leaf[i];
            end else begin : g_pad
                assign node[P-1+i] = '1;
            end
        end
        // Internal nodes: keep the smaller child, left child on equality.
        for (genvar n = 0; n < P-1; n++) begin : g_node
            assign node[n] = (node[2*n+2] < node[2*n+1]) ? node[2*n+2] : node[2*n+1];
        end
    endgenerate

    assign win_key = node[0];

endmodule

// File: rtl/trap_prio_sel.sv
// Trap priority selection unit (top). Gathers all pending exception
// requests of one instruction, picks the most urgent by ranking and then
// by trap code, and registers the valid flag and the 9-bit trap type.
// Assumes all requests belong to the same instruction in the same cycle.
module trap_prio_sel
    import tsel_pkg::*;
#(
    parameter int WIN_IDX_W = 5,
    parameter int SWT_W     = 7,
    parameter int INT_LVLS  = 15
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [FIX_N-1:0]               req_fixed,
    input  logic [WIN_SLOTS-1:0]           win_req,
    input  logic [WIN_SLOTS*WIN_IDX_W-1:0] win_idx,
    input  logic                           swt_req,
    input  logic [SWT_W-1:0]               swt_num,
    input  logic [INT_LVLS-1:0]            intr_pend,
    output logic                           trap_vld,
    output logic [TT_W-1:0]                trap_type
);

    localparam int LVL_W  = $clog2(INT_LVLS);
    localparam int N_CAND = FIX_N + WIN_SLOTS + 2;

    logic               intr_hit;
    logic [LVL_W-1:0]   intr_idx;
    logic [KEY_W-1:0]   cand [N_CAND];
    logic [KEY_W-1:0]   win_key;
    logic               win_idle;
    logic [PRIO_W-1:0]  win_prio;
    logic [TT_W-1:0]    win_code;

    tsel_irq_enc #(.INT_LVLS(INT_LVLS)) irq_enc_i (
        .intr_pend (intr_pend),
        .hit       (intr_hit),
        .top_idx   (intr_idx)
    );

    tsel_cand_gen #(
        .WIN_IDX_W (WIN_IDX_W),
        .SWT_W     (SWT_W),
        .INT_LVLS  (INT_LVLS)
    ) cand_gen_i (
        .req_fixed (req_fixed),
        .win_req   (win_req),
        .win_idx   (win_idx),
        .swt_req   (swt_req),
        .swt_num   (swt_num),
        .intr_hit  (intr_hit),
        .intr_idx  (intr_idx),
        .cand      (cand)
    );

    tsel_min_tree #(.N_IN(N_CAND), .KEY_W(KEY_W)) min_tree_i (
        .leaf    (cand),
        .win_key (win_key)
    );

    // Unpack the winning key into its fields.
    assign {win_idle, win_prio, win_code} = win_key;

    // Output register: clear on reset, zero code when nothing is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_vld  <= 1'b0;
            trap_type <= '0;
        end else begin
            trap_vld  <= ~win_idle;
            trap_type <= win_idle ? '0 : win_code;
        end
    end

    // R2
    por_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_fixed[1] |-> (win_prio == '0))
        else $error("por_rank_chk: power-on not ranked most urgent");

    // R2
    por_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_fixed[1] |=> (trap_vld && trap_type == TT_W'(1)))
        else $error("por_win_chk: power-on request did not win");

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_vld |-> (trap_type == '0))
        else $error("idle_zero_chk: nonzero type without valid");

    // R9
    swt_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swt_req |=> trap_vld)
        else $error("swt_vld_chk: request not followed by valid");

    // R6
    swt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld && trap_type[TT_W-1]) |-> $past(swt_req))
        else $error("swt_src_chk: software code without software request");

    // R5
    win_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld && trap_type[TT_W-1:TT_W-2] == 2'b01) |-> $past(|win_req))
        else $error("win_src_chk: window code without window request");

endmodule

// File: tb/trap_prio_sel_tb_top.sv
// Scoreboard bench: the driver computes expected results from the
// requirements and queues them; the monitor compares one cycle later.
module trap_prio_sel_tb_top;

    typedef struct {
        bit        vld;
        bit [8:0]  tt;
        string     tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] req_fixed = '0;
    logic [3:0]   win_req = '0;
    logic [19:0]  win_idx = '0;
    logic         swt_req = 1'b0;
    logic [6:0]   swt_num = '0;
    logic [14:0]  intr_pend = '0;
    logic         trap_vld;
    logic [8:0]   trap_type;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    trap_prio_sel dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_fixed (req_fixed),
        .win_req   (win_req),
        .win_idx   (win_idx),
        .swt_req   (swt_req),
        .swt_num   (swt_num),
        .intr_pend (intr_pend),
        .trap_vld  (trap_vld),
        .trap_type (trap_type)
    );

    // Ranking table written from R4; 99 marks an unlisted code.
    function automatic int rank_of(int c);
        if (c == 'h01) return 0;
        if (c >= 'h02 && c <= 'h05) return 1;
        if (c == 'h09 || c == 'h40) return 2;
        if (c == 'h0A) return 3;
        if (c == 'h29) return 4;
        if (c == 'h08) return 5;
        if (c >= 'h11 && c <= 'h13) return 6;
        if (c == 'h10) return 7;
        if (c == 'h20) return 8;
        if (c == 'h24 || c == 'h34 || c == 'h35 || c == 'h36 || c == 'h38 || c == 'h39) return 10;
        if (c == 'h21 || c == 'h22 || c == 'h37) return 11;
        if (c >= 'h30 && c <= 'h33) return 12;
        if (c == 'h23) return 14;
        if (c == 'h28) return 15;
        return 99;
    endfunction

    task automatic consider(int r, int c, inout int br, inout int bc);
        if (r < br || (r == br && c < bc)) begin
            br = r;
            bc = c;
        end
    endtask

    // Driver: compute the expected winner of the current inputs and queue it.
    task automatic send(string tag);
        int br = 99;
        int bc = 0;
        exp_t e;
        for (int k = 0; k < 128; k++)
            if (req_fixed[k] && rank_of(k) != 99) consider(rank_of(k), k, br, bc);
        for (int s = 0; s < 4; s++)
            if (win_req[s]) consider(9, 'h80 + 'h20 * s + int'(win_idx[s*5 +: 5]), br, bc);
        if (swt_req) consider(16, 'h100 + int'(swt_num), br, bc);
        for (int j = 14; j >= 0; j--)
            if (intr_pend[j]) begin
                consider(2, 'h41 + j, br, bc);
                break;
            end
        e.vld = (br != 99);
        e.tt  = (br != 99) ? 9'(bc) : 9'h0;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic clear_in();
        req_fixed = '0; win_req = '0; win_idx = '0;
        swt_req = 1'b0; swt_num = '0; intr_pend = '0;
    endtask

    // Monitor: compare the registered outputs shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (trap_vld !== e.vld || trap_type !== e.tt) begin
                n_fail++;
                $display("FAIL %s: got vld=%0b type=%03h, expected vld=%0b type=%03h",
                         e.tag, trap_vld, trap_type, e.vld, e.tt);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: requests held during reset must not reach the outputs.
        req_fixed[1] = 1'b1; swt_req = 1'b1; intr_pend = 15'h7FFF;
        repeat (3) @(negedge clk);
        n_chk++;
        if (trap_vld !== 1'b0 || trap_type !== 9'h0) begin
            n_fail++;
            $display("FAIL R1: got vld=%0b type=%03h, expected vld=0 type=000", trap_vld, trap_type);
        end
        clear_in();
        rst_n = 1'b1;

        // R10 / R9: nothing pending.
        @(negedge clk); send("R10 idle");
        // R8: unlisted fixed codes alone.
        @(negedge clk); req_fixed[6] = 1; req_fixed['h41] = 1; req_fixed['h7F] = 1; send("R8 unlisted only");
        @(negedge clk); req_fixed['h25] = 1; req_fixed['h28] = 1; send("R8 unlisted beside 0x028");
        // R2: everything pending.
        @(negedge clk); clear_in();
        for (int k = 0; k < 128; k++) req_fixed[k] = 1'b1;
        win_req = 4'hF; swt_req = 1; intr_pend = 15'h7FFF; send("R2 all pending");
        // R9: drop back to nothing.
        @(negedge clk); clear_in(); send("R9 drop");
        // R3: ties inside a level.
        @(negedge clk); req_fixed[5] = 1; req_fixed[3] = 1; req_fixed[4] = 1; send("R3 resets tie");
        @(negedge clk); clear_in(); req_fixed['h33] = 1; req_fixed['h31] = 1; send("R3 data tie");
        @(negedge clk); clear_in(); req_fixed['h40] = 1; intr_pend = 15'h4000; send("R3 async vs irq");
        @(negedge clk); clear_in(); win_req = 4'b1001; win_idx = {5'd0, 5'd0, 5'd0, 5'd2}; send("R3 spill vs fill");
        // R4: across levels.
        @(negedge clk); clear_in(); req_fixed['h10] = 1; req_fixed['h11] = 1; send("R4 illegal vs priv");
        @(negedge clk); clear_in(); req_fixed['h23] = 1; req_fixed['h28] = 1; send("R4 tag vs div");
        @(negedge clk); clear_in(); req_fixed['h08] = 1; req_fixed['h29] = 1; send("R4 ipe vs access");
        // R5: window composition.
        @(negedge clk); clear_in(); req_fixed['h34] = 1; win_req = 4'b0010; win_idx = {5'd0, 5'd0, 5'd3, 5'd0}; send("R5 spill other beats misalign");
        @(negedge clk); clear_in(); win_req = 4'b1000; win_idx = {5'd31, 5'd0, 5'd0, 5'd0}; send("R5 fill other idx31");
        @(negedge clk); clear_in(); win_req = 4'b0100; win_idx = {5'd0, 5'd17, 5'd0, 5'd0}; req_fixed['h20] = 1; send("R5 fill normal vs fp disabled");
        // R6: software trap.
        @(negedge clk); clear_in(); swt_req = 1; swt_num = 7'h7F; send("R6 swt max");
        @(negedge clk); req_fixed['h28] = 1; send("R6 swt loses to div");
        // R7: interrupts.
        @(negedge clk); clear_in(); intr_pend = 15'b000_0001_0000_0100; send("R7 highest level");
        @(negedge clk); req_fixed['h0A] = 1; intr_pend = 15'h0001; send("R7 irq beats 0x00A");
        @(negedge clk); req_fixed['h09] = 1; intr_pend = 15'h4000; send("R7 0x009 beats irq");
        // R4: random sparse mixes.
        for (int it = 0; it < 300; it++) begin
            @(negedge clk); clear_in();
            for (int b = 0; b < 3; b++) req_fixed[$urandom % 72] = ($urandom % 4) != 0;
            if ($urandom % 3 == 0) win_req = 4'($urandom);
            win_idx = 20'($urandom);
            swt_req = ($urandom % 4) == 0; swt_num = 7'($urandom);
            if ($urandom % 4 == 0) intr_pend = 15'($urandom);
            send("R4 random");
        end
        @(negedge clk); clear_in(); send("R9 final drop");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule